// File: doc/BRIEF.md
# Programmable ROM Pointer Read Port

This block lets a host fetch bytes from a large data ROM through a programmable 24-bit pointer. The host writes byte-wide registers: a base pointer, a 16-bit adjust value, a 16-bit step value and a mode byte. A strobe on the sequential port fetches the byte at the pointer, then moves the pointer by a step. A strobe on the adjusted port fetches the byte at base plus adjust. The ROM is synchronous: it captures an address in the cycle `rom_req` is high and presents its data in the next cycle.

The mode byte controls how the pointer moves. It selects the step source and its signedness, the signedness of the adjust value, whether the adjust takes part in the sequential address, and whether the step lands on the base or on the adjust. It also selects an optional base-plus-adjust update. That update fires either when the adjust pair is written or after an adjusted-port read. A mode write stays latent until both adjust bytes have been written. ROM access stays off after reset until the bank byte of the base has once been written non-zero.

Top module: `rom_ptr_port`

## Requirements
- R1: After reset every register is zero, direct access is off, and `rd_valid` and `rom_req` are low.
- R2: Direct access turns on when the bank byte (offset 2) is written with a non-zero value, and it stays on after the bank is set back to zero. While it is off, a read gives `rd_valid` with data 0x00, raises no `rom_req` and leaves the pointer unchanged.
- R3: A strobe is accepted only when no fetch is outstanding. `rom_req` and `rom_addr` appear in the same cycle as the strobe, and `rd_data` with `rd_valid` follows two cycles later for one cycle. A strobe in the cycle right after an accepted one is ignored. When both strobes are high, `rd_seq` wins.
- R4: With mode bit 1 set, the sequential address is base plus the extended adjust. With bit 1 clear it is the base alone.
- R5: After a sequential read the step is 1 when mode bit 0 is clear, or the step register (offsets 5 low, 6 high) when bit 0 is set. Mode bit 2 sign-extends the step register.
- R6: With mode bit 4 clear the step is added to the 24-bit base. With bit 4 set it is added to the 16-bit adjust, which wraps at 16 bits, and the base stays unchanged.
- R7: Mode bit 3 sign-extends the adjust (offsets 3 low, 4 high). When bit 3 is clear the adjust is zero-extended. All address sums wrap at 24 bits.
- R8: The adjusted port reads base plus adjust, whatever the state of mode bit 1. It leaves the pointer unchanged unless bits 6:5 are 11.
- R9: Mode bits 6:5 = 01 add the low adjust byte (extended per bit 3) to the base when the adjust pair completes. Bits 6:5 = 10 add the full adjust at that moment.
- R10: With mode bits 6:5 = 11, each adjusted-port read sets the base to base plus adjust. Nothing is added when the adjust pair is written.
- R11: A mode write (offset 7) takes effect only when both adjust bytes have been written since the last time the mode took effect, in either order.
- R12: Base bytes sit at offsets 0 (low), 1 (middle) and 2 (bank), and each write replaces only its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Register write byte |
| rd_seq | input | 1 | Sequential read strobe |
| rd_adj | input | 1 | Adjusted read strobe |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Read data |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 24 | ROM byte address |
| rom_data | input | 8 | ROM data, valid the cycle after `rom_req` |

## Verification
The ROM address is combinational, so the bench samples `rom_addr` and `rom_req` in the same cycle as the strobe, half a period after driving it. The returned byte is due two edges later. One edge is the ROM register and one is the capture register, so the bench checks `rd_data` at the second falling edge after the strobe and checks that `rd_valid` is low again one cycle later. Pointer and mode effects have no port of their own. The bench proves them through the `rom_addr` of the next read, issued only after the previous fetch has returned. Register writes take effect at the edge that follows them.

// File: rtl/rpp_pkg.sv
package rpp_pkg;
  typedef struct packed {
    logic       spare;
    logic [1:0] extra;
    logic       step_to_adj;
    logic       adj_signed;
    logic       step_signed;
    logic       adj_en;
    logic       use_step;
  } mode_t;

  localparam logic [1:0] EXTRA_NONE  = 2'b00;
  localparam logic [1:0] EXTRA_WR8   = 2'b01;
  localparam logic [1:0] EXTRA_WR16  = 2'b10;
  localparam logic [1:0] EXTRA_ADJRD = 2'b11;

  typedef enum logic [1:0] {FK_IDLE, FK_SEQ, FK_ADJ} fetch_kind_t;
endpackage

// File: rtl/rpp_addr.sv
module rpp_addr #(
  parameter int DW = 8,
  parameter int AB = 3,
  parameter int OB = 2,
  localparam int AW = DW * AB,
  localparam int OW = DW * OB
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] adj,
  input  logic [OW-1:0] step,
  input  logic          use_step,
  input  logic          step_signed,
  input  logic          adj_signed,
  input  logic          adj_en,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] adj_addr,
  output logic [AW-1:0] base_step,
  output logic [OW-1:0] adj_step
);
  logic [AW-1:0] adj_ext;
  logic [AW-1:0] step_ext;
  logic [OW-1:0] step_val;

  always_comb begin
    adj_ext   = {{(AW-OW){adj_signed & adj[OW-1]}}, adj};
    step_val  = use_step ? step : OW'(1);
    step_ext  = {{(AW-OW){use_step & step_signed & step[OW-1]}}, step_val};
    adj_addr  = base + adj_ext;
    seq_addr  = adj_en ? adj_addr : base;
    base_step = base + step_ext;
    adj_step  = adj + step_val;
  end
endmodule

// File: rtl/rpp_fetch.sv
module rpp_fetch import rpp_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_seq,
  input  logic          rd_adj,
  input  logic          en,
  input  logic [DW-1:0] rom_data,
  output logic          rom_req,
  output logic          done_seq,
  output logic          done_adj,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  fetch_kind_t   kind_q, kind_nx;
  logic          live_q, live_nx;
  logic          accept;
  logic          valid_nx;
  logic [DW-1:0] data_nx;
  logic          data_ld;

  always_comb begin
    accept   = (rd_seq | rd_adj) & (kind_q == FK_IDLE);
    kind_nx  = accept ? (rd_seq ? FK_SEQ : FK_ADJ) : FK_IDLE;
    live_nx  = accept & en;
    rom_req  = accept & en;
    done_seq = (kind_q == FK_SEQ) & live_q;
    done_adj = (kind_q == FK_ADJ) & live_q;
    valid_nx = kind_q != FK_IDLE;
    data_ld  = kind_q != FK_IDLE;
    data_nx  = live_q ? rom_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= FK_IDLE;
      live_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      kind_q   <= kind_nx;
      live_q   <= live_nx;
      rd_valid <= valid_nx;
      if (data_ld) rd_data <= data_nx;
    end
  end
endmodule

// File: rtl/rpp_regs.sv
module rpp_regs import rpp_pkg::*; #(
  parameter int DW = 8,
  parameter int AB = 3,
  parameter int OB = 2,
  localparam int AW   = DW * AB,
  localparam int OW   = DW * OB,
  localparam int NREG = AB + 2 * OB + 1,
  localparam int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           done_seq,
  input  logic           done_adj,
  input  logic [AW-1:0]  base_step,
  input  logic [OW-1:0]  adj_step,
  input  logic [AW-1:0]  base_adj_sum,
  output logic [AW-1:0]  base_q,
  output logic [OW-1:0]  adj_q,
  output logic [OW-1:0]  step_q,
  output mode_t          mode_q,
  output logic           en_q
);
  localparam int ADJ0     = AB;
  localparam int STEP0    = AB + OB;
  localparam int MODE_OFS = AB + 2 * OB;

  logic [AW-1:0] base_nx;
  logic [OW-1:0] adj_nx, step_nx;
  mode_t         mode_nx, shadow_q, shadow_nx;
  logic [OB-1:0] seen_q, seen_nx;
  logic          en_nx;
  logic          pair_done;
  logic          upd;
  logic [AW-1:0] ext_lo, ext_full;

  always_comb begin
    base_nx   = base_q;
    adj_nx    = adj_q;
    step_nx   = step_q;
    mode_nx   = mode_q;
    shadow_nx = shadow_q;
    seen_nx   = seen_q;
    en_nx     = en_q;
    if (wr_en) begin
      for (int i = 0; i < AB; i++)
        if (int'(wr_addr) == i) base_nx[i*DW +: DW] = wr_data;
      for (int i = 0; i < OB; i++) begin
        if (int'(wr_addr) == ADJ0 + i) begin
          adj_nx[i*DW +: DW] = wr_data;
          seen_nx[i]         = 1'b1;
        end
        if (int'(wr_addr) == STEP0 + i) step_nx[i*DW +: DW] = wr_data;
      end
      if (int'(wr_addr) == MODE_OFS) shadow_nx = mode_t'(wr_data[$bits(mode_t)-1:0]);
      if ((int'(wr_addr) == AB - 1) && (wr_data != '0)) en_nx = 1'b1;
    end
    ext_lo    = {{(AW-DW){shadow_nx.adj_signed & adj_nx[DW-1]}}, adj_nx[DW-1:0]};
    ext_full  = {{(AW-OW){shadow_nx.adj_signed & adj_nx[OW-1]}}, adj_nx};
    pair_done = &seen_nx;
    if (pair_done) begin
      seen_nx = '0;
      mode_nx = shadow_nx;
      case (shadow_nx.extra)
        EXTRA_WR8:  base_nx = base_nx + ext_lo;
        EXTRA_WR16: base_nx = base_nx + ext_full;
        default: ;
      endcase
    end
    if (done_seq) begin
      if (mode_q.step_to_adj) adj_nx = adj_step;
      else                    base_nx = base_step;
    end
    if (done_adj && (mode_q.extra == EXTRA_ADJRD)) base_nx = base_adj_sum;
    upd = wr_en | done_seq | done_adj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      adj_q    <= '0;
      step_q   <= '0;
      mode_q   <= '0;
      shadow_q <= '0;
      seen_q   <= '0;
      en_q     <= 1'b0;
    end else if (upd) begin
      base_q   <= base_nx;
      adj_q    <= adj_nx;
      step_q   <= step_nx;
      mode_q   <= mode_nx;
      shadow_q <= shadow_nx;
      seen_q   <= seen_nx;
      en_q     <= en_nx;
    end
  end
endmodule

// File: rtl/rom_ptr_port.sv
module rom_ptr_port import rpp_pkg::*; #(
  parameter int DW = 8,
  parameter int AB = 3,
  parameter int OB = 2,
  localparam int AW   = DW * AB,
  localparam int OW   = DW * OB,
  localparam int NREG = AB + 2 * OB + 1,
  localparam int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_seq,
  input  logic           rd_adj,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           rom_req,
  output logic [AW-1:0]  rom_addr,
  input  logic [DW-1:0]  rom_data
);
  logic          rst_meta_q, rst_sync_n;
  logic [AW-1:0] base_q, seq_addr, adj_addr, base_step;
  logic [OW-1:0] adj_q, step_q, adj_step;
  mode_t         mode_q;
  logic          dir_en, done_seq, done_adj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rpp_regs #(.DW(DW), .AB(AB), .OB(OB)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_seq(done_seq), .done_adj(done_adj),
    .base_step(base_step), .adj_step(adj_step), .base_adj_sum(adj_addr),
    .base_q(base_q), .adj_q(adj_q), .step_q(step_q), .mode_q(mode_q), .en_q(dir_en)
  );

  rpp_addr #(.DW(DW), .AB(AB), .OB(OB)) u_addr (
    .base(base_q), .adj(adj_q), .step(step_q),
    .use_step(mode_q.use_step), .step_signed(mode_q.step_signed),
    .adj_signed(mode_q.adj_signed), .adj_en(mode_q.adj_en),
    .seq_addr(seq_addr), .adj_addr(adj_addr),
    .base_step(base_step), .adj_step(adj_step)
  );

  rpp_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_seq(rd_seq), .rd_adj(rd_adj), .en(dir_en), .rom_data(rom_data),
    .rom_req(rom_req), .done_seq(done_seq), .done_adj(done_adj),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign rom_addr = rd_seq ? seq_addr : adj_addr;
endmodule

// File: rtl/rpp_check.sv
module rpp_check #(
  parameter int DW = 8,
  parameter int AB = 3,
  parameter int OB = 2,
  localparam int AW   = DW * AB,
  localparam int NREG = AB + 2 * OB + 1,
  localparam int RAW  = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [RAW-1:0] wr_addr,
  input logic           rom_req,
  input logic           rd_valid,
  input logic [DW-1:0]  rd_data,
  input logic           en,
  input logic [7:0]     mode,
  input logic [AW-1:0]  base
);
  logic adj_wr;
  assign adj_wr = wr_en && (int'(wr_addr) >= AB) && (int'(wr_addr) < AB + OB);

  assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> en);
  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  assert_base_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(base));
  assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rom_req, 2)) |-> (rd_data == '0));
  assert_data_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |=> ##1 rd_valid);
  assert_single_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_no_req_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |=> !rom_req);
  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !adj_wr |=> $stable(mode));
endmodule

bind rom_ptr_port rpp_check #(.DW(DW), .AB(AB), .OB(OB)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rom_req(rom_req), .rd_valid(rd_valid), .rd_data(rd_data),
  .en(dir_en), .mode(mode_q), .base(base_q)
);

// File: tb/rom_ptr_port_tb.sv
`timescale 1ns/1ps
module rom_ptr_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_seq, rd_adj;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data, rd_data, rom_data;
  logic        rd_valid, rom_req;
  logic [23:0] rom_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rom_ptr_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_seq(rd_seq), .rd_adj(rd_adj), .rd_valid(rd_valid), .rd_data(rd_data),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_data(rom_data)
  );

  function automatic logic [7:0] romv(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rom_req) rom_data <= romv(rom_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_base(input logic [23:0] b);
    wr(3'd0, b[7:0]); wr(3'd1, b[15:8]); wr(3'd2, b[23:16]);
  endtask

  task automatic set_mode(input logic [7:0] m, input logic [15:0] a);
    wr(3'd7, m); wr(3'd3, a[7:0]); wr(3'd4, a[15:8]);
  endtask

  task automatic rd(input bit adj_port, input logic [23:0] exp, input string tag);
    @(negedge clk); rd_seq = !adj_port; rd_adj = adj_port;
    #1;
    chk(rom_req === 1'b1, {tag, " rom_req"}, 32'(rom_req), 32'd1);
    chk(rom_addr === exp, {tag, " rom_addr"}, 32'(rom_addr), 32'(exp));
    @(negedge clk); rd_seq = 1'b0; rd_adj = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === romv(exp), {tag, " rd_data"}, 32'(rd_data), 32'(romv(exp)));
  endtask

  task automatic rd_off(input string tag);
    @(negedge clk); rd_seq = 1'b1;
    #1 chk(rom_req === 1'b0, {tag, " no rom_req"}, 32'(rom_req), 32'd0);
    @(negedge clk); rd_seq = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === 8'h00, {tag, " zero data"}, 32'(rd_data), 32'd0);
  endtask

  task automatic t_reset;
    chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
    chk(rom_req === 1'b0, "R1 rom_req", 32'(rom_req), 32'd0);
    rd_off("R1 disabled after reset");
  endtask

  task automatic t_enable;
    wr(3'd0, 8'h34);
    rd_off("R2 off read");
    wr(3'd2, 8'h12);
    wr(3'd2, 8'h00);
    rd(1'b0, 24'h000034, "R2 R12 sticky enable, pointer kept");
    rd(1'b0, 24'h000035, "R5 unit step");
  endtask

  task automatic t_timing;
    @(negedge clk); rd_seq = 1'b1;
    #1 chk(rom_req === 1'b1 && rom_addr === 24'h000036, "R3 first", 32'(rom_addr), 32'h36);
    @(negedge clk);
    #1 chk(rom_req === 1'b0, "R3 strobe while pending ignored", 32'(rom_req), 32'd0);
    @(negedge clk); rd_seq = 1'b0;
    chk(rd_valid === 1'b1 && rd_data === romv(24'h36), "R3 data due", 32'(rd_data), 32'(romv(24'h36)));
    @(negedge clk);
    chk(rd_valid === 1'b0, "R3 one-cycle valid", 32'(rd_valid), 32'd0);
    rd(1'b0, 24'h000037, "R3 single advance");
  endtask

  task automatic t_commit;
    wr(3'd5, 8'h10); wr(3'd6, 8'h00);
    wr(3'd7, 8'h01);
    set_base(24'h001000);
    rd(1'b0, 24'h001000, "R11 mode latent");
    wr(3'd4, 8'h00); wr(3'd3, 8'h00);
    rd(1'b0, 24'h001001, "R11 still unit step before commit");
    rd(1'b0, 24'h001011, "R5 R11 step register after commit");
  endtask

  task automatic t_signed_step;
    wr(3'd5, 8'hF0); wr(3'd6, 8'hFF);
    set_base(24'h002000);
    rd(1'b0, 24'h002000, "R5 unsigned base");
    rd(1'b0, 24'h011FF0, "R5 unsigned step 0xFFF0");
    set_mode(8'h05, 16'h0000);
    set_base(24'h002000);
    rd(1'b0, 24'h002000, "R5 signed base");
    rd(1'b0, 24'h001FF0, "R5 signed step -16");
  endtask

  task automatic t_adj_addr;
    set_mode(8'h02, 16'h0100);
    set_base(24'h003000);
    rd(1'b0, 24'h003100, "R4 adj added");
    rd(1'b0, 24'h003101, "R4 R6 step to base");
    set_mode(8'h0A, 16'hFF00);
    rd(1'b0, 24'h002F02, "R7 signed adj");
    set_mode(8'h00, 16'h0100);
    rd(1'b0, 24'h003003, "R4 adj disabled");
  endtask

  task automatic t_step_adj;
    set_mode(8'h12, 16'hFFFF);
    set_base(24'h004000);
    rd(1'b0, 24'h013FFF, "R6 R7 unsigned adj");
    rd(1'b0, 24'h004000, "R6 adj wraps 16 bits");
    rd(1'b0, 24'h004001, "R6 base unchanged");
  endtask

  task automatic t_adj_port;
    set_mode(8'h00, 16'h0010);
    set_base(24'h005000);
    rd(1'b1, 24'h005010, "R8 adj port");
    rd(1'b0, 24'h005000, "R8 pointer kept");
    @(negedge clk); rd_seq = 1'b1; rd_adj = 1'b1;
    #1 chk(rom_addr === 24'h005001, "R3 seq priority", 32'(rom_addr), 32'h5001);
    @(negedge clk); rd_seq = 1'b0; rd_adj = 1'b0;
    @(negedge clk);
    rd(1'b0, 24'h005002, "R3 priority advanced base");
    set_base(24'hFFFFF0);
    rd(1'b1, 24'h000000, "R8 24-bit wrap up");
    set_mode(8'h08, 16'hFFF0);
    set_base(24'h000005);
    rd(1'b1, 24'hFFFFF5, "R8 R7 24-bit wrap down");
  endtask

  task automatic t_write_add;
    set_base(24'h006000);
    set_mode(8'h40, 16'h0200);
    rd(1'b0, 24'h006200, "R9 16-bit add on pair");
    set_base(24'h007000);
    set_mode(8'h28, 16'h12F0);
    rd(1'b0, 24'h006FF0, "R9 8-bit signed add");
    set_mode(8'h20, 16'h34F0);
    rd(1'b0, 24'h0070E1, "R9 8-bit unsigned add");
  endtask

  task automatic t_read_add;
    set_base(24'h008000);
    set_mode(8'h60, 16'h0004);
    rd(1'b0, 24'h008000, "R10 no add on write");
    rd(1'b1, 24'h008005, "R10 adj read");
    rd(1'b0, 24'h008005, "R10 base moved");
    rd(1'b1, 24'h00800A, "R10 second adj read");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_seq = 1'b0; rd_adj = 1'b0; rom_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_timing();
    t_commit();
    t_signed_step();
    t_adj_addr();
    t_step_adj();
    t_adj_port();
    t_write_add();
    t_read_add();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule